// File: doc/BRIEF.md
# Permuted Bank Mapper with Open-Row Tracking

This block sits at the front of a DRAM controller. It takes a physical request address and splits it into a column (offset within a page), a bank and a row. Instead of taking the bank straight from the address, it XORs the bank field with the low bits of the tag region above it. Addresses that conflict in a set-indexed cache would otherwise pile onto one bank with different rows. With the XOR they are spread across banks. Addresses within a page still share one bank, and successive pages still rotate over every bank.

Alongside the mapping, the block keeps an open-row record for every bank and uses an open-page policy. Each accepted access is classified in one of three ways:
- a hit on the open row,
- a miss on a closed (precharged) bank, or
- a conflict with a different open row.

It reports the service latency in cycles for that class. The bank's record then becomes the accessed row. A single-cycle flush closes every bank.

Requests arrive on a valid/ready port. A request is taken on a clock edge where both valid and ready are high. Ready is low only during a flush cycle, so a request presented then is held off by the requester and not lost. Results leave on a valid-only port one cycle after acceptance and cannot be back-pressured.

Top module: `rbm_bank_mapper`

## Requirements
- R1: With default widths (32-bit address, 11 column bits, 5 bank bits), the column equals address bits [10:0] and the row equals address bits [31:16], both unchanged.
- R2: The output bank equals address bits [15:11] XOR address bits [TAG_LSB+4:TAG_LSB], with TAG_LSB defaulting to 16.
- R3: Two addresses differing only in column bits map to the same bank.
- R4: Two addresses with equal bank field but different low tag bits map to different banks.
- R5: The 32 consecutive pages sharing one row value map onto all 32 banks, one page per bank.
- R6: After reset every bank is closed, so the first access to any bank is class 1 (closed miss) with latency LAT_CLOSED (default 8).
- R7: An access to the row that is open in its bank is class 0 (hit) with latency LAT_HIT (default 4).
- R8: An access to a bank holding a different open row is class 2 (conflict) with latency LAT_CONFLICT (default 14).
- R9: Every accepted access leaves its row open in its bank, so repeating it gives a hit.
- R10: While flush is high, in_ready is low, no request is accepted, and every bank is closed afterwards.
- R11: out_valid is high for exactly one cycle, in the cycle after each accepted request, and low otherwise.
- R12: With BYPASS set to 1 the output bank equals address bits [15:11] unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Close all banks this cycle |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_addr | input | ADDR_W | Physical request address |
| out_valid | output | 1 | Result present for one cycle |
| out_bank | output | BANK_W | Permuted bank index |
| out_row | output | ADDR_W-COL_W-BANK_W | Row index |
| out_col | output | COL_W | Column (page offset) |
| out_class | output | 2 | 0 hit, 1 closed miss, 2 conflict |
| out_lat | output | LAT_W | Service latency in cycles |

## Verification
The bench builds two copies from the same stimulus. The first uses default parameters (32 banks, 2 KB pages, XOR source at bit 16), so hits, closed misses and conflicts can be driven on the same bank through both row and bank-field changes. The second is built with BYPASS=1, so every request also shows plain interleaving next to the permuted result. With the 5-bit bank field, a sweep of 32 pages covers every bank and proves that the permutation spreads pages uniformly.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [1:0] {
    ACC_HIT      = 2'd0,
    ACC_CLOSED   = 2'd1,
    ACC_CONFLICT = 2'd2
  } acc_class_e;
endpackage

// File: rtl/rbm_addr_split.sv
module rbm_addr_split #(
  parameter int ADDR_W  = 32,
  parameter int COL_W   = 11,
  parameter int BANK_W  = 5,
  parameter int TAG_LSB = 16,
  parameter bit BYPASS  = 1'b0
) (
  input  logic [ADDR_W-1:0]              addr,
  output logic [BANK_W-1:0]              bank,
  output logic [ADDR_W-COL_W-BANK_W-1:0] row,
  output logic [COL_W-1:0]               col
);
  localparam int ROW_W = ADDR_W - COL_W - BANK_W;
  localparam int BF_LSB = COL_W;

  logic [BANK_W-1:0] bank_field;

  assign col        = addr[COL_W-1:0];
  assign bank_field = addr[BF_LSB +: BANK_W];
  assign row        = addr[ADDR_W-1 -: ROW_W];

  generate
    if (BYPASS) begin : g_plain
      assign bank = bank_field;
    end else begin : g_perm
      assign bank = bank_field ^ addr[TAG_LSB +: BANK_W];
    end
  endgenerate
endmodule

// File: rtl/rbm_row_tracker.sv
module rbm_row_tracker
  import rbm_pkg::*;
#(
  parameter int BANK_W = 5,
  parameter int ROW_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              upd_en,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  output acc_class_e        cls
);
  localparam int NBANK = 1 << BANK_W;

  logic [NBANK-1:0] open_vld;
  logic [ROW_W-1:0] open_row [NBANK];

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          open_vld[b] <= 1'b0;
          open_row[b] <= '0;
        end else if (flush) begin
          open_vld[b] <= 1'b0;
        end else if (upd_en && bank == BANK_W'(b)) begin
          open_vld[b] <= 1'b1;
          open_row[b] <= row;
        end
      end
    end
  endgenerate

  always_comb begin
    if (!open_vld[bank])            cls = ACC_CLOSED;
    else if (open_row[bank] == row) cls = ACC_HIT;
    else                            cls = ACC_CONFLICT;
  end

  // R10: a lookup right after a flush must see a closed bank
  p_flush_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && !flush && upd_en) |-> cls == ACC_CLOSED);

  // R9: repeating the previous access on the same bank finds its row open
  p_reopen_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_en) && !$past(flush) && upd_en && !flush &&
     bank == $past(bank) && row == $past(row)) |-> cls == ACC_HIT);
endmodule

// File: rtl/rbm_bank_mapper.sv
module rbm_bank_mapper
  import rbm_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int COL_W        = 11,
  parameter int BANK_W       = 5,
  parameter int TAG_LSB      = 16,
  parameter bit BYPASS       = 1'b0,
  parameter int LAT_W        = 8,
  parameter int LAT_HIT      = 4,
  parameter int LAT_CLOSED   = 8,
  parameter int LAT_CONFLICT = 14
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [ADDR_W-1:0]              in_addr,
  output logic                           out_valid,
  output logic [BANK_W-1:0]              out_bank,
  output logic [ADDR_W-COL_W-BANK_W-1:0] out_row,
  output logic [COL_W-1:0]               out_col,
  output logic [1:0]                     out_class,
  output logic [LAT_W-1:0]               out_lat
);
  localparam int ROW_W = ADDR_W - COL_W - BANK_W;

  logic              accept;
  logic [BANK_W-1:0] m_bank;
  logic [ROW_W-1:0]  m_row;
  logic [COL_W-1:0]  m_col;
  acc_class_e        m_cls;
  logic [LAT_W-1:0]  m_lat;

  assign in_ready = ~flush;
  assign accept   = in_valid & in_ready;

  rbm_addr_split #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W),
    .TAG_LSB(TAG_LSB), .BYPASS(BYPASS)
  ) u_split (
    .addr(in_addr), .bank(m_bank), .row(m_row), .col(m_col)
  );

  rbm_row_tracker #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_track (
    .clk(clk), .rst_n(rst_n), .flush(flush), .upd_en(accept),
    .bank(m_bank), .row(m_row), .cls(m_cls)
  );

  always_comb begin
    unique case (m_cls)
      ACC_HIT:    m_lat = LAT_W'(LAT_HIT);
      ACC_CLOSED: m_lat = LAT_W'(LAT_CLOSED);
      default:    m_lat = LAT_W'(LAT_CONFLICT);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bank  <= '0;
      out_row   <= '0;
      out_col   <= '0;
      out_class <= '0;
      out_lat   <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_bank  <= m_bank;
        out_row   <= m_row;
        out_col   <= m_col;
        out_class <= m_cls;
        out_lat   <= m_lat;
      end
    end
  end

  // R11: one result per accepted request, one cycle later
  p_result_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);

  // R10: nothing is taken during a flush
  p_flush_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  // R7, R8: reported latency agrees with the reported class
  p_hit_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'd0) |-> out_lat == LAT_W'(LAT_HIT));
  p_conflict_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'd2) |-> out_lat == LAT_W'(LAT_CONFLICT));
endmodule

// File: tb/rbm_bank_mapper_test.sv
module rbm_bank_mapper_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        in_ready, out_valid;
  logic [4:0]  out_bank;
  logic [15:0] out_row;
  logic [10:0] out_col;
  logic [1:0]  out_class;
  logic [7:0]  out_lat;
  logic        b_ready, b_valid;
  logic [4:0]  b_bank;
  logic [15:0] b_row;
  logic [10:0] b_col;
  logic [1:0]  b_class;
  logic [7:0]  b_lat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rbm_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .out_valid(out_valid),
    .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
    .out_class(out_class), .out_lat(out_lat)
  );

  rbm_bank_mapper #(.BYPASS(1'b1)) uut_byp (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(b_ready), .in_addr(in_addr), .out_valid(b_valid),
    .out_bank(b_bank), .out_row(b_row), .out_col(b_col),
    .out_class(b_class), .out_lat(b_lat)
  );

  // vectors applied after reset, in order: row, bank field, column, expected bank, class
  localparam logic [15:0] V_ROW [8] = '{16'h0003, 16'h0003, 16'h0004, 16'h0004,
                                        16'h0013, 16'h0003, 16'h0023, 16'h0023};
  localparam logic [4:0]  V_BF  [8] = '{5'd2, 5'd2, 5'd5, 5'd5, 5'd2, 5'd2, 5'd2, 5'd2};
  localparam logic [10:0] V_COL [8] = '{11'h010, 11'h7FF, 11'h000, 11'h005,
                                        11'h123, 11'h001, 11'h002, 11'h003};
  localparam logic [4:0]  V_BNK [8] = '{5'd1, 5'd1, 5'd1, 5'd1, 5'd17, 5'd1, 5'd1, 5'd1};
  localparam logic [1:0]  V_CLS [8] = '{2'd1, 2'd0, 2'd2, 2'd0, 2'd1, 2'd2, 2'd2, 2'd0};

  function automatic logic [31:0] mk(logic [15:0] r, logic [4:0] bf, logic [10:0] c);
    return {r, bf, c};
  endfunction

  function automatic logic [7:0] lat_of(logic [1:0] c);
    return (c == 2'd0) ? 8'd4 : (c == 2'd1) ? 8'd8 : 8'd14;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one request and sample its result at the following falling edge
  task automatic send(logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 out_valid", out_valid, 1);
    check("R12 bypass bank", b_bank, a[15:11]);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seen;
    repeat (3) @(negedge clk);
    check("R11 reset out_valid", out_valid, 0);
    check("R10 reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle out_valid", out_valid, 0);

    for (int i = 0; i < 8; i++) begin
      send(mk(V_ROW[i], V_BF[i], V_COL[i]));
      check("R2 bank", out_bank, V_BNK[i]);
      check("R1 row", out_row, V_ROW[i]);
      check("R1 col", out_col, V_COL[i]);
      check("R6 R7 R8 class", out_class, V_CLS[i]);
      check("R6 R7 R8 latency", out_lat, lat_of(V_CLS[i]));
    end

    // R11: the result lasts one cycle only
    @(negedge clk);
    check("R11 pulse width", out_valid, 0);

    // R10: flush blocks a request and closes bank 1 (open row 0x23)
    @(negedge clk);
    flush = 1'b1;
    in_valid = 1'b1;
    in_addr = mk(16'h0023, 5'd2, 11'h0);
    #1 check("R10 ready low", in_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    in_valid = 1'b0;
    check("R10 not accepted", out_valid, 0);
    send(mk(16'h0023, 5'd2, 11'h0));
    check("R10 closed after flush", out_class, 2'd1);
    check("R6 closed latency", out_lat, 8'd8);

    // R3: same page, other column, same bank and hit
    send(mk(16'h0023, 5'd2, 11'h7F0));
    check("R3 same page bank", out_bank, 5'd1);
    check("R9 reopened hit", out_class, 2'd0);

    // R4: same bank field, different tag bits
    send(mk(16'h0005, 5'd9, 11'h0));
    check("R4 tag 5 bank", out_bank, 5'd12);
    send(mk(16'h0006, 5'd9, 11'h0));
    check("R4 tag 6 bank", out_bank, 5'd15);

    // R5: 32 consecutive pages of one row reach all banks
    seen = '0;
    for (int j = 0; j < 32; j++) begin
      send(mk(16'h0007, 5'(j), 11'h0));
      seen[out_bank] = 1'b1;
    end
    check("R5 bank coverage", seen, 32'hFFFF_FFFF);

    // R8 then R9: conflict opens new row, repeat hits
    send(mk(16'h0008, 5'd0, 11'h0));
    check("R8 conflict class", out_class, 2'd2);
    check("R8 conflict latency", out_lat, 8'd14);
    send(mk(16'h0008, 5'd0, 11'h4));
    check("R9 hit after conflict", out_class, 2'd0);
    check("R7 hit latency", out_lat, 8'd4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule